// File: doc/BRIEF.md
# Color Subcarrier Phase Generator with Field-Locked Re-phasing

This block produces the color subcarrier for a video encoder. A 32-bit phase accumulator advances on every 27 MHz clock by a programmable frequency word. To keep the subcarrier phase tied to line timing, a small controller counts field strobes and, at a selectable interval, loads the accumulator with a programmable start phase. This re-phasing only takes place when the encoder produces an interlaced signal.

The upper bits of the phase address a quarter-wave magnitude table, from which signed sine and cosine samples are derived. These samples drive a quadrature modulator that forms chroma as U·sin + V·cos. The block then adds luminance, scales the sum by 15/16 to leave headroom, and clamps the result into an unsigned composite sample.

The re-phasing controller is a two-state machine. In `ST_OFF`, no re-phasing is allowed. In `ST_ARMED`, re-phasing is allowed on qualifying field strobes. Two transitions connect them. `ARM` moves from `ST_OFF` to `ST_ARMED` when the mode is non-zero and the interlaced flag is high. `DISARM` moves from `ST_ARMED` back to `ST_OFF` as soon as either condition drops. Every other case holds the current state.

Top module: `subcarrier_dto`

## Requirements
- R1: With no re-phase event, `phase_o` increases by `freq_word` modulo 2^32 on every clock edge.
- R2: The block counts field strobes from 0, starting at reset release. When a strobe's count value is a multiple of the selected period and the controller is armed, `phase_o` takes `start_phase` at that same clock edge. The frequency word is not added on that edge.
- R3: `rephase_mode` encodes the period: 2'b00 means never re-phase, 2'b01 every 2 fields, 2'b10 every 4 fields, 2'b11 every 8 fields.
- R4: While `interlaced` is low, field strobes never re-phase the accumulator. Changes to `interlaced` and `rephase_mode` take effect one clock after they are applied.
- R5: `sin_o` is derived from the phase bits. Bits [31:30] give the quadrant and bits [29:22] give k. The quarter-wave magnitude is m(j) = (127·j·(512−j)) >> 16. By quadrant 0..3, `sin_o` is +m(k), +m(256−k), −m(k), −m(256−k).
- R6: `cos_o` uses the same k and m. By quadrant 0..3, `cos_o` is +m(256−k), −m(k), −m(256−k), +m(k).
- R7: One clock after U and V are presented, `chroma_o` = floor((U·sin + V·cos)/128). U and V are signed 8-bit values. The sine and cosine are those of the phase present at that edge.
- R8: `cvbs_o` is computed on the same edge as `chroma_o`. With s = Y + chroma (Y unsigned 8-bit), `cvbs_o` = clamp(s − floor(s/16), 0, 511).
- R9: After reset, `phase_o`, `chroma_o` and `cvbs_o` are all zero, and the field count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | 32 | Phase increment per clock |
| start_phase | input | 32 | Phase loaded on a re-phase event |
| rephase_mode | input | 2 | Re-phase interval select |
| interlaced | input | 1 | High when producing an interlaced signal |
| field_stb | input | 1 | One-clock pulse at field start |
| u_in | input | 8 | Signed U baseband sample |
| v_in | input | 8 | Signed V baseband sample |
| y_in | input | 8 | Unsigned luminance sample |
| phase_o | output | 32 | Accumulator phase |
| sin_o | output | 8 | Signed sine sample |
| cos_o | output | 8 | Signed cosine sample |
| chroma_o | output | 9 | Signed modulated chroma, registered |
| cvbs_o | output | 9 | Unsigned composite sample, registered |

## Verification
The bench runs every re-phase mode through sixteen field strobes, counted from reset. It checks phase on each strobe edge. A wrong period mapping would load the start phase on the wrong fields, and an off-by-one field count would load it one field late. It repeats the strobes with the interlaced flag low, where any load of the start phase is a defect.

The bench then fixes the phase at each of the 1024 table addresses and checks sine, cosine, chroma and composite. This catches quadrant mirroring errors, such as reading m(255−k) instead of m(256−k), which would lose the peak value. It also catches a logical instead of arithmetic shift in the 15/16 scaling, and a missing low clamp, which would wrap negative sums to large positive composite codes.

// File: rtl/scdto_pkg.sv
package scdto_pkg;

    typedef enum logic [0:0] {
        ST_OFF   = 1'b0,
        ST_ARMED = 1'b1
    } rephase_state_e;

    // Quarter-wave magnitude: parabolic half-wave shape sampled over a quarter
    function automatic longint qmag(input int k, input int qw, input int amp);
        longint n2;
        n2 = longint'(2) << qw;
        return (longint'(amp) * longint'(k) * (n2 - longint'(k))) >> (2 * qw);
    endfunction

endpackage

// File: rtl/scdto_field_fsm.sv
module scdto_field_fsm
    import scdto_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_stb,
    input  logic       interlaced,
    input  logic [1:0] mode,
    output logic       rephase
);

    rephase_state_e     state_q, state_d;
    logic [CNT_W-1:0]   fcnt_q;
    logic [CNT_W-1:0]   mask;
    logic               arm_ok;

    assign arm_ok = (mode != 2'b00) && interlaced;

    always_comb begin
        unique case (mode)
            2'b01:   mask = CNT_W'(1);
            2'b10:   mask = CNT_W'(3);
            2'b11:   mask = CNT_W'(7);
            default: mask = '1;
        endcase
    end

    // state register and field counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (field_stb)
                fcnt_q <= fcnt_q + CNT_W'(1);
        end
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        rephase = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (arm_ok)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!arm_ok)
                    state_d = ST_OFF;
                rephase = field_stb && ((fcnt_q & mask) == '0);
            end
            default: state_d = ST_OFF;
        endcase
    end

endmodule

// File: rtl/scdto_accum.sv
module scdto_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] step,
    input  logic [ACC_W-1:0] init,
    output logic [ACC_W-1:0] acc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (load)
            acc <= init;
        else
            acc <= acc + step;
    end

endmodule

// File: rtl/scdto_sincos.sv
module scdto_sincos
    import scdto_pkg::*;
#(
    parameter int PH_W  = 10,
    parameter int AMP_W = 8
) (
    input  logic [PH_W-1:0]         addr,
    output logic signed [AMP_W-1:0] sin_v,
    output logic signed [AMP_W-1:0] cos_v
);

    localparam int QW  = PH_W - 2;
    localparam int NQ  = 1 << QW;
    localparam int AMP = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-2:0] qtab [0:NQ];

    for (genvar k = 0; k <= NQ; k++) begin : g_tab
        assign qtab[k] = (AMP_W-1)'(qmag(k, QW, AMP));
    end

    logic [1:0]       quad;
    logic [QW-1:0]    q;
    logic [QW:0]      qr;
    logic signed [AMP_W-1:0] pf, pr;

    assign quad = addr[PH_W-1 -: 2];
    assign q    = addr[QW-1:0];
    assign qr   = (QW+1)'(NQ) - {1'b0, q};
    assign pf   = $signed({1'b0, qtab[q]});
    assign pr   = $signed({1'b0, qtab[qr]});

    always_comb begin
        unique case (quad)
            2'd0: begin sin_v =  pf; cos_v =  pr; end
            2'd1: begin sin_v =  pr; cos_v = -pf; end
            2'd2: begin sin_v = -pf; cos_v = -pr; end
            default: begin sin_v = -pr; cos_v =  pf; end
        endcase
    end

endmodule

// File: rtl/scdto_mixer.sv
module scdto_mixer #(
    parameter int DW    = 8,
    parameter int AMP_W = 8,
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [AMP_W-1:0] sin_v,
    input  logic signed [AMP_W-1:0] cos_v,
    input  logic signed [DW-1:0]    u,
    input  logic signed [DW-1:0]    v,
    input  logic [DW-1:0]           y,
    output logic signed [DW:0]      chroma,
    output logic [OUT_W-1:0]        cvbs
);

    localparam int MW = DW + AMP_W + 1;
    localparam int CW = DW + 1;
    localparam int SW = CW + 2;
    localparam logic signed [SW-1:0] OMAX = SW'((1 << OUT_W) - 1);

    logic signed [MW-1:0] uu, vv, ss, cc, mac, sh;
    logic signed [CW-1:0] chroma_n;
    logic signed [SW-1:0] sum, scaled;
    logic [OUT_W-1:0]     cvbs_n;

    assign uu  = MW'(u);
    assign vv  = MW'(v);
    assign ss  = MW'(sin_v);
    assign cc  = MW'(cos_v);
    assign mac = uu * ss + vv * cc;
    assign sh  = mac >>> (AMP_W - 1);
    assign chroma_n = sh[CW-1:0];

    assign sum    = SW'(chroma_n) + $signed({{(SW-DW){1'b0}}, y});
    assign scaled = sum - (sum >>> 4);

    always_comb begin
        if (scaled < 0)
            cvbs_n = '0;
        else if (scaled > OMAX)
            cvbs_n = '1;
        else
            cvbs_n = scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chroma <= '0;
            cvbs   <= '0;
        end else begin
            chroma <= chroma_n;
            cvbs   <= cvbs_n;
        end
    end

endmodule

// File: rtl/subcarrier_dto.sv
module subcarrier_dto #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int AMP_W = 8,
    parameter int DW    = 8,
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        freq_word,
    input  logic [ACC_W-1:0]        start_phase,
    input  logic [1:0]              rephase_mode,
    input  logic                    interlaced,
    input  logic                    field_stb,
    input  logic signed [DW-1:0]    u_in,
    input  logic signed [DW-1:0]    v_in,
    input  logic [DW-1:0]           y_in,
    output logic [ACC_W-1:0]        phase_o,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o,
    output logic signed [DW:0]      chroma_o,
    output logic [OUT_W-1:0]        cvbs_o
);

    localparam int CNT_W = 3;

    logic rephase;

    scdto_field_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_stb  (field_stb),
        .interlaced (interlaced),
        .mode       (rephase_mode),
        .rephase    (rephase)
    );

    scdto_accum #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rephase),
        .step  (freq_word),
        .init  (start_phase),
        .acc   (phase_o)
    );

    scdto_sincos #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
        .addr  (phase_o[ACC_W-1 -: PH_W]),
        .sin_v (sin_o),
        .cos_v (cos_o)
    );

    scdto_mixer #(.DW(DW), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .sin_v  (sin_o),
        .cos_v  (cos_o),
        .u      (u_in),
        .v      (v_in),
        .y      (y_in),
        .chroma (chroma_o),
        .cvbs   (cvbs_o)
    );

endmodule

// File: rtl/scdto_checker.sv
module scdto_checker #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ACC_W-1:0]        freq_word,
    input logic [1:0]              rephase_mode,
    input logic                    interlaced,
    input logic                    field_stb,
    input logic [ACC_W-1:0]        phase_o,
    input logic signed [AMP_W-1:0] sin_o,
    input logic signed [AMP_W-1:0] cos_o
);

    localparam logic signed [AMP_W-1:0] NEG_PEAK = -AMP_W'((1 << (AMP_W - 1)) - 1);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(field_stb)) |-> (phase_o == $past(phase_o) + $past(freq_word))); // R1

    AST_MODE_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && ($past(rephase_mode) == 2'b00) && ($past(rephase_mode, 2) == 2'b00))
        |-> (phase_o == $past(phase_o) + $past(freq_word))); // R3

    AST_PROGRESSIVE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && !$past(interlaced) && !$past(interlaced, 2))
        |-> (phase_o == $past(phase_o) + $past(freq_word))); // R4

    AST_SIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        sin_o >= NEG_PEAK); // R5

    AST_COS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        cos_o >= NEG_PEAK); // R6

endmodule

bind subcarrier_dto scdto_checker #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_word    (freq_word),
    .rephase_mode (rephase_mode),
    .interlaced   (interlaced),
    .field_stb    (field_stb),
    .phase_o      (phase_o),
    .sin_o        (sin_o),
    .cos_o        (cos_o)
);

// File: tb/subcarrier_dto_bench.sv
module subcarrier_dto_bench;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        freq_word = '0;
    logic [31:0]        start_phase = '0;
    logic [1:0]         rephase_mode = '0;
    logic               interlaced = 1'b0;
    logic               field_stb = 1'b0;
    logic signed [7:0]  u_in = '0;
    logic signed [7:0]  v_in = '0;
    logic [7:0]         y_in = '0;
    logic [31:0]        phase_o;
    logic signed [7:0]  sin_o, cos_o;
    logic signed [8:0]  chroma_o;
    logic [8:0]         cvbs_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_phase;
    int          nstb;

    subcarrier_dto u_subcarrier_dto (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .start_phase(start_phase),
        .rephase_mode(rephase_mode), .interlaced(interlaced), .field_stb(field_stb),
        .u_in(u_in), .v_in(v_in), .y_in(y_in), .phase_o(phase_o), .sin_o(sin_o),
        .cos_o(cos_o), .chroma_o(chroma_o), .cvbs_o(cvbs_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mag(input int j);
        return (127 * j * (512 - j)) >>> 16;
    endfunction

    function automatic int exp_sin(input logic [31:0] ph);
        int k = int'(ph[29:22]);
        case (ph[31:30])
            2'd0: return  mag(k);
            2'd1: return  mag(256 - k);
            2'd2: return -mag(k);
            default: return -mag(256 - k);
        endcase
    endfunction

    function automatic int exp_cos(input logic [31:0] ph);
        int k = int'(ph[29:22]);
        case (ph[31:30])
            2'd0: return  mag(256 - k);
            2'd1: return -mag(k);
            2'd2: return -mag(256 - k);
            default: return  mag(k);
        endcase
    endfunction

    function automatic int period(input logic [1:0] m);
        case (m)
            2'b01: return 2;
            2'b10: return 4;
            2'b11: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_phase = '0;
        nstb = 0;
    endtask

    // one clock: drive at negedge, model edge, return at next negedge
    task automatic step(input logic stb);
        int p;
        field_stb = stb;
        @(posedge clk);
        p = period(rephase_mode);
        if (stb && interlaced && p != 0 && (nstb % p) == 0)
            exp_phase = start_phase;
        else
            exp_phase = exp_phase + freq_word;
        if (stb) nstb++;
        @(negedge clk);
        field_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9 reset state
        do_reset();
        chk("R9 phase after reset", phase_o, 0);
        chk("R9 chroma after reset", chroma_o, 0);
        chk("R9 cvbs after reset", cvbs_o, 0);

        // R1 free-running accumulation with wrap
        freq_word = 32'h21F0_7C1F;
        for (int i = 0; i < 40; i++) begin
            step(1'b0);
            chk("R1 accumulate", phase_o, exp_phase);
        end
        freq_word = 32'hF000_0001;
        for (int i = 0; i < 8; i++) begin
            step(1'b0);
            chk("R1 wrap", phase_o, exp_phase);
        end

        // R2 R3 every mode, interlaced
        freq_word   = 32'h21F0_7C1F;
        start_phase = 32'h1234_5678;
        interlaced  = 1'b1;
        for (int m = 0; m < 4; m++) begin
            rephase_mode = 2'(m);
            do_reset();
            step(1'b0);
            step(1'b0);
            for (int f = 0; f < 16; f++) begin
                step(1'b1);
                chk($sformatf("R2 R3 mode %0d field %0d", m, f), phase_o, exp_phase);
                for (int i = 0; i < 3; i++) step(1'b0);
                chk("R1 between fields", phase_o, exp_phase);
            end
        end

        // R4 non-interlaced: strobes never reload
        interlaced = 1'b0;
        for (int m = 1; m < 4; m++) begin
            rephase_mode = 2'(m);
            do_reset();
            step(1'b0);
            step(1'b0);
            for (int f = 0; f < 10; f++) begin
                step(1'b1);
                chk($sformatf("R4 progressive mode %0d field %0d", m, f), phase_o, exp_phase);
                step(1'b0);
            end
        end

        // R5 R6 R7 R8 sweep of all table addresses at fixed phase
        interlaced   = 1'b1;
        rephase_mode = 2'b01;
        freq_word    = '0;
        do_reset();
        step(1'b0);
        for (int k = 0; k < 1024; k++) begin
            int es, ec, ech, sum, sc;
            start_phase = 32'(k) << 22;
            u_in = 8'(k * 37 + 3);
            v_in = 8'(k * 91 + 5);
            y_in = 8'(k * 13);
            step(1'b1);
            step(1'b1);
            step(1'b0);
            step(1'b0);
            es  = exp_sin(start_phase);
            ec  = exp_cos(start_phase);
            ech = (int'(u_in) * es + int'(v_in) * ec) >>> 7;
            sum = int'(y_in) + ech;
            sc  = sum - (sum >>> 4);
            if (sc < 0) sc = 0;
            if (sc > 511) sc = 511;
            chk("R2 phase fixed", phase_o, start_phase);
            chk("R5 sine", sin_o, es);
            chk("R6 cosine", cos_o, ec);
            chk("R7 chroma", chroma_o, ech);
            chk("R8 composite", cvbs_o, sc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule